// File: doc/BRIEF.md
# Banked Plug-and-Play Configuration Register Space

This block holds the configuration state of a multi-function peripheral chip behind an index/data register pair. The host first writes an 8-bit register number to the index port, then reads or writes the data port to reach that register. One group of registers is global and shared by the whole chip: a device-select register, a read-only chip identifier, a read-only revision byte and nine writable chip-level configuration bytes. A second group exists once per logical device. The value in the device-select register chooses which device's copy the host sees.

Each logical device has its own copy of an enable bit, one or two 16-bit I/O base addresses, an interrupt line number with a wake-on-interrupt flag, an interrupt type, and two DMA channel numbers. The block compares a host I/O address against the ranges of all enabled devices and raises a one-hot hit for the device that owns the address. It also presents each device's interrupt and DMA selections. A device that is not enabled has no hit and shows all-zero interrupt and DMA selections.

Host accesses use a valid/ready request channel. A read returns its byte on a valid/ready response channel. The request channel stalls (`req_ready` low) while a read response is waiting. A response holds its data unchanged until the host takes it with `rsp_ready`.

Top module: `cfg_bank_space`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_is_data`=0 addresses the index port and `req_is_data`=1 addresses the data port. A write to the index port stores the register number. A read of the index port returns that number. A data-port read returns the register the stored number selects, with `rsp_valid` high from the next cycle.
- R2: After reset the device-select register, all global configuration bytes and all per-device registers are zero. `dev_hit` and all interrupt and DMA outputs are zero, `rsp_valid` is low and `req_ready` is high.
- R3: Register 20h returns the `CHIP_ID` parameter and register 27h returns the `CHIP_REV` parameter. Writes to either register have no effect.
- R4: Registers 21h–26h and 28h–2Ah are read/write bytes shared by all devices. They read the same value whatever device is selected.
- R5: Register 07h selects the logical device. Registers 30h and above reach only the selected device's copy, and writing one device's copy leaves every other device's copy unchanged.
- R6: Register 30h bit 0 enables the device. Bits 7–1 are not stored and read as zero.
- R7: Registers 60h and 61h hold bits 15–8 and 7–0 of base address 0. An enabled device hits for every I/O address with base ≤ address < base + `RANGE`.
- R8: Registers 62h and 63h hold base address 1, in the same byte order, only on devices whose bit is set in `D1_MASK`. On those devices base address 1 decodes like base address 0. On other devices 62h and 63h read zero and ignore writes.
- R9: Register 70h holds the interrupt number in bits 3–0 and the wake enable in bit 4. Register 71h holds the interrupt type in bits 1–0. Registers 74h and 75h hold DMA channel 0 and DMA channel 1 in bits 2–0. All other bits of these registers read zero.
- R10: For device i, the `dev_irq_num`, `dev_irq_wake`, `dev_irq_type`, `dev_dma0` and `dev_dma1` slices show the stored fields while the device is enabled. While the device is disabled these slices are zero and `dev_hit[i]` is zero. Device i uses bits [4i+3:4i] of `dev_irq_num`, [2i+1:2i] of `dev_irq_type` and [3i+2:3i] of the DMA outputs.
- R11: While the device-select value is `NDEV` or higher, per-device reads return 00h and per-device writes change no device.
- R12: Unimplemented and reserved register numbers read 00h and ignore writes.
- R13: When the ranges of several enabled devices contain the same address, only the lowest-numbered device hits. `dev_hit` is never more than one-hot.
- R14: While `rsp_valid` is high, `req_ready` is low. A pending response keeps `rsp_valid` high and `rsp_rdata` unchanged until a cycle with `rsp_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is_data | input | 1 | 0 = index port, 1 = data port |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host accepts the response |
| rsp_rdata | output | 8 | Read response byte |
| io_addr | input | 16 | Host I/O address to decode |
| dev_hit | output | NDEV | One-hot decode hit per device |
| dev_irq_num | output | 4*NDEV | Interrupt number per device |
| dev_irq_wake | output | NDEV | Wake-on-interrupt enable per device |
| dev_irq_type | output | 2*NDEV | Interrupt type per device |
| dev_dma0 | output | 3*NDEV | DMA channel 0 per device |
| dev_dma1 | output | 3*NDEV | DMA channel 1 per device |

## Verification
The bench builds the block with `NDEV`=4, `RANGE`=8 and `D1_MASK`=4'b0010.

With four devices, selecting device 5 reaches the out-of-range select case of R11, and bank isolation is still visible across several banks. Because only device 1 has a second base address, the enabled and missing cases of R8 can be checked side by side. The range size of 8 lets the bench put two enabled devices on overlapping ranges that share a few addresses, which exercises the priority rule of R13 at both ends of the shared part.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int IRQ_W  = 4;
  localparam int ITYP_W = 2;
  localparam int DMA_W  = 3;

  localparam logic [7:0] IX_LDN   = 8'h07;
  localparam logic [7:0] IX_ID    = 8'h20;
  localparam logic [7:0] IX_GLO   = 8'h21;
  localparam logic [7:0] IX_REV   = 8'h27;
  localparam logic [7:0] IX_GHI   = 8'h2A;
  localparam logic [7:0] IX_ACT   = 8'h30;
  localparam logic [7:0] IX_B0H   = 8'h60;
  localparam logic [7:0] IX_B0L   = 8'h61;
  localparam logic [7:0] IX_B1H   = 8'h62;
  localparam logic [7:0] IX_B1L   = 8'h63;
  localparam logic [7:0] IX_IRQ   = 8'h70;
  localparam logic [7:0] IX_ITYP  = 8'h71;
  localparam logic [7:0] IX_DMA0  = 8'h74;
  localparam logic [7:0] IX_DMA1  = 8'h75;

  localparam int GCFG_N = int'(IX_GHI) - int'(IX_GLO) + 1;

  typedef struct packed {
    logic              act;
    logic [15:0]       base0;
    logic [15:0]       base1;
    logic [IRQ_W-1:0]  irq_num;
    logic              wake;
    logic [ITYP_W-1:0] irq_type;
    logic [DMA_W-1:0]  dma0;
    logic [DMA_W-1:0]  dma1;
  } dev_cfg_t;

endpackage

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_space_pkg::*;
#(
  parameter logic [7:0] CHIP_ID  = 8'hE9,
  parameter logic [7:0] CHIP_REV = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] ldn,
  output logic [7:0] rdata,
  output logic       hit
);

  logic [7:0] ldn_q;
  logic [7:0] gcfg_q [GCFG_N];
  logic       in_gcfg;
  logic [7:0] goff;

  assign goff    = idx - IX_GLO;
  assign in_gcfg = (idx >= IX_GLO) && (idx <= IX_GHI) && (idx != IX_REV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldn_q <= '0;
      for (int i = 0; i < GCFG_N; i++) gcfg_q[i] <= '0;
    end else if (we) begin
      if (idx == IX_LDN) ldn_q <= wdata;
      for (int i = 0; i < GCFG_N; i++)
        if (in_gcfg && goff == 8'(i)) gcfg_q[i] <= wdata;
    end
  end

  always_comb begin
    hit   = 1'b1;
    rdata = '0;
    if (idx == IX_LDN)      rdata = ldn_q;
    else if (idx == IX_ID)  rdata = CHIP_ID;
    else if (idx == IX_REV) rdata = CHIP_REV;
    else if (in_gcfg) begin
      for (int i = 0; i < GCFG_N; i++)
        if (goff == 8'(i)) rdata = gcfg_q[i];
    end else hit = 1'b0;
  end

  assign ldn = ldn_q;

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_space_pkg::*;
#(
  parameter bit HAS_D1 = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output dev_cfg_t   cfg,
  output logic [7:0] rdata
);

  dev_cfg_t q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      case (idx)
        IX_ACT:  q.act         <= wdata[0];
        IX_B0H:  q.base0[15:8] <= wdata;
        IX_B0L:  q.base0[7:0]  <= wdata;
        IX_B1H:  if (HAS_D1) q.base1[15:8] <= wdata;
        IX_B1L:  if (HAS_D1) q.base1[7:0]  <= wdata;
        IX_IRQ: begin
          q.irq_num <= wdata[IRQ_W-1:0];
          q.wake    <= wdata[IRQ_W];
        end
        IX_ITYP: q.irq_type <= wdata[ITYP_W-1:0];
        IX_DMA0: q.dma0     <= wdata[DMA_W-1:0];
        IX_DMA1: q.dma1     <= wdata[DMA_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IX_ACT:  rdata = {7'b0, q.act};
      IX_B0H:  rdata = q.base0[15:8];
      IX_B0L:  rdata = q.base0[7:0];
      IX_B1H:  rdata = HAS_D1 ? q.base1[15:8] : 8'h00;
      IX_B1L:  rdata = HAS_D1 ? q.base1[7:0]  : 8'h00;
      IX_IRQ:  rdata = {3'b0, q.wake, q.irq_num};
      IX_ITYP: rdata = {6'b0, q.irq_type};
      IX_DMA0: rdata = {5'b0, q.dma0};
      IX_DMA1: rdata = {5'b0, q.dma1};
      default: rdata = '0;
    endcase
  end

  assign cfg = q;

endmodule

// File: rtl/cfg_io_decode.sv
module cfg_io_decode
  import cfg_space_pkg::*;
#(
  parameter int              NDEV    = 8,
  parameter int              RANGE   = 8,
  parameter logic [NDEV-1:0] D1_MASK = '0
) (
  input  logic [15:0]     io_addr,
  input  dev_cfg_t        cfg [NDEV],
  output logic [NDEV-1:0] hit
);

  localparam logic [16:0] SPAN = 17'(RANGE);

  logic [NDEV-1:0] raw;

  for (genvar i = 0; i < NDEV; i++) begin : g_rng
    logic in0;
    logic in1;
    assign in0 = ({1'b0, io_addr} >= {1'b0, cfg[i].base0}) &&
                 ({1'b0, io_addr} <  ({1'b0, cfg[i].base0} + SPAN));
    if (D1_MASK[i]) begin : g_d1
      assign in1 = ({1'b0, io_addr} >= {1'b0, cfg[i].base1}) &&
                   ({1'b0, io_addr} <  ({1'b0, cfg[i].base1} + SPAN));
    end else begin : g_nod1
      assign in1 = 1'b0;
    end
    assign raw[i] = cfg[i].act && (in0 || in1);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    hit   = '0;
    for (int i = 0; i < NDEV; i++) begin
      if (raw[i] && !found) begin
        hit[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_bank_space.sv
module cfg_bank_space
  import cfg_space_pkg::*;
#(
  parameter int              NDEV     = 8,
  parameter int              RANGE    = 8,
  parameter logic [NDEV-1:0] D1_MASK  = NDEV'(6),
  parameter logic [7:0]      CHIP_ID  = 8'hE9,
  parameter logic [7:0]      CHIP_REV = 8'h01
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic                   req_is_data,
  input  logic [7:0]             req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [7:0]             rsp_rdata,
  input  logic [15:0]            io_addr,
  output logic [NDEV-1:0]        dev_hit,
  output logic [NDEV*IRQ_W-1:0]  dev_irq_num,
  output logic [NDEV-1:0]        dev_irq_wake,
  output logic [NDEV*ITYP_W-1:0] dev_irq_type,
  output logic [NDEV*DMA_W-1:0]  dev_dma0,
  output logic [NDEV*DMA_W-1:0]  dev_dma1
);

  localparam int SEL_W = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic            fire;
  logic            wr_data;
  logic [7:0]      idx_q;
  logic [7:0]      ldn;
  logic [7:0]      glb_rd;
  logic            glb_hit;
  logic [7:0]      bank_rd [NDEV];
  dev_cfg_t        bank_cfg [NDEV];
  logic [NDEV-1:0] act_vec;
  logic            sel_ok;
  logic [7:0]      data_rd;
  logic [7:0]      rd_byte;
  logic            rsp_v_q;
  logic [7:0]      rsp_d_q;

  assign req_ready = !rsp_v_q;
  assign fire      = req_valid && req_ready;
  assign wr_data   = fire && req_write && req_is_data;
  assign sel_ok    = ldn < 8'(NDEV);

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (fire && req_write && !req_is_data) idx_q <= req_wdata;
  end

  cfg_global_regs #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_glb (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_data),
    .idx   (idx_q),
    .wdata (req_wdata),
    .ldn   (ldn),
    .rdata (glb_rd),
    .hit   (glb_hit)
  );

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    cfg_dev_bank #(.HAS_D1(D1_MASK[i])) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_data && (ldn == 8'(i))),
      .idx   (idx_q),
      .wdata (req_wdata),
      .cfg   (bank_cfg[i]),
      .rdata (bank_rd[i])
    );
    assign act_vec[i] = bank_cfg[i].act;
    assign dev_irq_num[i*IRQ_W +: IRQ_W]    = act_vec[i] ? bank_cfg[i].irq_num  : '0;
    assign dev_irq_wake[i]                  = act_vec[i] && bank_cfg[i].wake;
    assign dev_irq_type[i*ITYP_W +: ITYP_W] = act_vec[i] ? bank_cfg[i].irq_type : '0;
    assign dev_dma0[i*DMA_W +: DMA_W]       = act_vec[i] ? bank_cfg[i].dma0     : '0;
    assign dev_dma1[i*DMA_W +: DMA_W]       = act_vec[i] ? bank_cfg[i].dma1     : '0;
  end

  cfg_io_decode #(.NDEV(NDEV), .RANGE(RANGE), .D1_MASK(D1_MASK)) u_dec (
    .io_addr (io_addr),
    .cfg     (bank_cfg),
    .hit     (dev_hit)
  );

  always_comb begin
    data_rd = '0;
    if (glb_hit) data_rd = glb_rd;
    else if (idx_q >= IX_ACT && sel_ok) data_rd = bank_rd[ldn[SEL_W-1:0]];
  end

  assign rd_byte = req_is_data ? data_rd : idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else if (fire && !req_write) begin
      rsp_v_q <= 1'b1;
      rsp_d_q <= rd_byte;
    end else if (rsp_v_q && rsp_ready) begin
      rsp_v_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_d_q;

endmodule

// File: rtl/cfg_bank_space_chk.sv
module cfg_bank_space_chk
  import cfg_space_pkg::*;
#(
  parameter int NDEV = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  req_write,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [7:0]            rsp_rdata,
  input logic [NDEV-1:0]       dev_hit,
  input logic [NDEV-1:0]       act_vec,
  input logic [NDEV*IRQ_W-1:0] dev_irq_num,
  input logic [NDEV*DMA_W-1:0] dev_dma0
);

  assert_read_answers_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  assert_stall_R14: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_hold_rsp_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_single_hit_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_hit));

  for (genvar i = 0; i < NDEV; i++) begin : g_q
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !act_vec[i] |-> (!dev_hit[i] && dev_irq_num[i*IRQ_W +: IRQ_W] == '0 &&
                       dev_dma0[i*DMA_W +: DMA_W] == '0));
  end

endmodule

bind cfg_bank_space cfg_bank_space_chk #(.NDEV(NDEV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .dev_hit     (dev_hit),
  .act_vec     (act_vec),
  .dev_irq_num (dev_irq_num),
  .dev_dma0    (dev_dma0)
);

// File: tb/sim_cfg_bank_space.sv
module sim_cfg_bank_space;

  localparam int         PERIOD = 10;
  localparam int         NDEV   = 4;
  localparam logic [7:0] ID     = 8'hE9;
  localparam logic [7:0] REV    = 8'h31;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0, req_is_data = 0, rsp_ready = 1;
  logic [7:0] req_wdata = 0;
  logic [15:0] io_addr = 0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [NDEV-1:0] dev_hit, dev_irq_wake;
  logic [NDEV*4-1:0] dev_irq_num;
  logic [NDEV*2-1:0] dev_irq_type;
  logic [NDEV*3-1:0] dev_dma0, dev_dma1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  cfg_bank_space #(.NDEV(NDEV), .RANGE(8), .D1_MASK(4'b0010),
                   .CHIP_ID(ID), .CHIP_REV(REV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_is_data(req_is_data), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .io_addr(io_addr), .dev_hit(dev_hit), .dev_irq_num(dev_irq_num),
    .dev_irq_wake(dev_irq_wake), .dev_irq_type(dev_irq_type),
    .dev_dma0(dev_dma0), .dev_dma1(dev_dma1));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic isdata, input logic [7:0] v);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_is_data = isdata; req_wdata = v;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic get(input logic isdata, output logic [7:0] v);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_is_data = isdata;
    @(negedge clk);
    req_valid = 0;
    v = rsp_valid ? rsp_rdata : 8'hxx;
    @(negedge clk);
  endtask

  task automatic wreg(input logic [7:0] ix, input logic [7:0] v);
    put(0, ix); put(1, v);
  endtask

  task automatic rreg(input logic [7:0] ix, output logic [7:0] v);
    put(0, ix); get(1, v);
  endtask

  task automatic hit_at(input string tag, input logic [15:0] a, input logic [NDEV-1:0] exp);
    @(negedge clk); io_addr = a; #1;
    check(tag, dev_hit, exp);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R2 rsp_valid", rsp_valid, 0);
    check("R2 req_ready", req_ready, 1);
    check("R2 dev_hit", dev_hit, 0);
    check("R2 irq/dma", {dev_irq_num, dev_dma0, dev_dma1}, 0);
    rreg(8'h07, v); check("R2 ldn", v, 0);
    rreg(8'h30, v); check("R2 act", v, 0);
    rreg(8'h24, v); check("R2 gcfg", v, 0);
  endtask

  task automatic t_index();
    logic [7:0] v;
    put(0, 8'h5A); get(0, v); check("R1 index readback", v, 8'h5A);
  endtask

  task automatic t_ids();
    logic [7:0] v;
    wreg(8'h20, 8'h55); rreg(8'h20, v); check("R3 chip id", v, ID);
    wreg(8'h27, 8'h66); rreg(8'h27, v); check("R3 revision", v, REV);
  endtask

  task automatic t_global();
    logic [7:0] v;
    wreg(8'h07, 8'h00); wreg(8'h23, 8'hA5); wreg(8'h2A, 8'h3C);
    wreg(8'h07, 8'h02);
    rreg(8'h23, v); check("R4 shared 23h", v, 8'hA5);
    rreg(8'h2A, v); check("R4 shared 2Ah", v, 8'h3C);
  endtask

  task automatic t_banks();
    logic [7:0] v;
    wreg(8'h07, 8'h01); wreg(8'h60, 8'h12); wreg(8'h61, 8'h34);
    wreg(8'h07, 8'h02); wreg(8'h60, 8'hAB); wreg(8'h61, 8'h00);
    wreg(8'h07, 8'h01); rreg(8'h60, v); check("R5 bank1 60h", v, 8'h12);
    rreg(8'h61, v); check("R7 bank1 61h", v, 8'h34);
    wreg(8'h07, 8'h00); rreg(8'h60, v); check("R5 bank0 untouched", v, 8'h00);
  endtask

  task automatic t_activate();
    logic [7:0] v;
    wreg(8'h07, 8'h01); wreg(8'h30, 8'hFF);
    rreg(8'h30, v); check("R6 act bit only", v, 8'h01);
  endtask

  task automatic t_decode();
    hit_at("R7 base low", 16'h1234, 4'b0010);
    hit_at("R7 base top", 16'h123B, 4'b0010);
    hit_at("R7 past end", 16'h123C, 4'b0000);
    hit_at("R7 below base", 16'h1233, 4'b0000);
    hit_at("R10 inactive dev2", 16'hAB00, 4'b0000);
  endtask

  task automatic t_desc1();
    logic [7:0] v;
    wreg(8'h07, 8'h01); wreg(8'h62, 8'h20); wreg(8'h63, 8'h00);
    rreg(8'h62, v); check("R8 dev1 62h", v, 8'h20);
    hit_at("R8 second range", 16'h2004, 4'b0010);
    wreg(8'h07, 8'h00); wreg(8'h62, 8'h20); wreg(8'h30, 8'h01);
    rreg(8'h62, v); check("R8 dev0 no desc1", v, 8'h00);
    hit_at("R8 dev0 base0 at 0", 16'h0003, 4'b0001);
    wreg(8'h30, 8'h00);
  endtask

  task automatic t_irqdma();
    logic [7:0] v;
    wreg(8'h07, 8'h01);
    wreg(8'h70, 8'hFF); rreg(8'h70, v); check("R9 70h", v, 8'h1F);
    wreg(8'h71, 8'hFF); rreg(8'h71, v); check("R9 71h", v, 8'h03);
    wreg(8'h74, 8'hFF); rreg(8'h74, v); check("R9 74h", v, 8'h07);
    wreg(8'h75, 8'h0D); rreg(8'h75, v); check("R9 75h", v, 8'h05);
    check("R10 irq out", dev_irq_num[7:4], 4'hF);
    check("R10 wake out", dev_irq_wake[1], 1);
    check("R10 type out", dev_irq_type[3:2], 2'h3);
    check("R10 dma out", {dev_dma0[5:3], dev_dma1[5:3]}, 6'o75);
    wreg(8'h07, 8'h02); wreg(8'h70, 8'h03); wreg(8'h74, 8'h02);
    check("R10 inactive irq/dma", {dev_irq_num[11:8], dev_dma0[8:6]}, 0);
  endtask

  task automatic t_overlap();
    wreg(8'h07, 8'h02); wreg(8'h60, 8'h12); wreg(8'h61, 8'h30); wreg(8'h30, 8'h01);
    check("R10 active irq", dev_irq_num[11:8], 4'h3);
    hit_at("R13 shared addr", 16'h1235, 4'b0010);
    hit_at("R13 shared top", 16'h1237, 4'b0010);
    hit_at("R13 dev2 only", 16'h1231, 4'b0100);
  endtask

  task automatic t_ldn_oob();
    logic [7:0] v;
    wreg(8'h07, 8'h05); wreg(8'h30, 8'h01); wreg(8'h60, 8'h77);
    rreg(8'h30, v); check("R11 oob read", v, 8'h00);
    rreg(8'h70, v); check("R11 oob irq read", v, 8'h00);
    wreg(8'h07, 8'h00); rreg(8'h30, v); check("R11 dev0 act", v, 8'h00);
    rreg(8'h60, v); check("R11 dev0 base", v, 8'h00);
    wreg(8'h07, 8'h03); rreg(8'h60, v); check("R11 dev3 base", v, 8'h00);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    wreg(8'h50, 8'h77); rreg(8'h50, v); check("R12 idx 50h", v, 8'h00);
    wreg(8'h2C, 8'h77); rreg(8'h2C, v); check("R12 idx 2Ch", v, 8'h00);
    wreg(8'h07, 8'h01); wreg(8'h72, 8'h77); rreg(8'h72, v); check("R12 idx 72h", v, 8'h00);
    rreg(8'h70, v); check("R12 neighbours kept", v, 8'h1F);
  endtask

  task automatic t_backpressure();
    logic [7:0] first;
    logic [7:0] v;
    put(0, 8'h27);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_is_data = 1;
    @(negedge clk);
    req_valid = 0;
    first = rsp_rdata;
    check("R14 first data", first, REV);
    req_valid = 1; req_write = 1; req_is_data = 0; req_wdata = 8'h99;
    repeat (3) begin
      @(negedge clk);
      check("R14 held valid", rsp_valid, 1);
      check("R14 stalled", req_ready, 0);
      check("R14 held data", rsp_rdata, first);
    end
    req_valid = 0; req_write = 0;
    rsp_ready = 1;
    @(negedge clk);
    check("R14 released", rsp_valid, 0);
    get(0, v); check("R14 stalled write dropped", v, 8'h27);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_index();
    t_ids();
    t_global();
    t_banks();
    t_activate();
    t_decode();
    t_desc1();
    t_irqdma();
    t_overlap();
    t_ldn_oob();
    t_unimpl();
    t_backpressure();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      repeat (50000) @(posedge clk);
    join_any
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule